// File: doc/BRIEF.md
# Trigger-Clocked Up-Counting Timer

This block is a 16-bit up-counting timer. Its counting clock can come from the system clock, or from the rising edges of one of four internal trigger lines, such as the trigger outputs of neighbouring timers. A 16-bit prescaler divides that timer clock into a counter-advance tick. The counter climbs from zero to a programmable period, wraps to zero, and raises a sticky overflow flag.

Software reaches the block through one write-enable and data group per field: control (run enable and counting mode), slave setup (slave mode and trigger select), period, and prescaler divide. A divide value that software writes is held in a shadow register. The prescaler takes it up only when the next overflow occurs, so a running count period never changes length partway through.

Top module: `trig_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the run enable is 0, the counting mode is 2'b00, the slave mode and trigger select are 3'b000, and both the active and the shadow divide values are 0.
- R2: With an active divide value D, the counter advances once every D+1 timer-clock ticks. D = 0 advances it on every tick.
- R3: On each advance the count rises by 1. An advance taken while the count is greater than or equal to the period instead sets the count to 0 and is an overflow event. A period of 0 makes every advance an overflow. A period write takes effect at once.
- R4: A divide write lands only in the shadow register. At an overflow event the prescaler counter returns to 0 and the active divide takes the shadow value.
- R5: While the run enable (ctrlEnable, written with ctrlWe) is 0, both the counter and the prescaler hold.
- R6: Only counting mode 2'b00 (up) counts. Any other mode value holds the counter and the prescaler.
- R7: In slave mode 3'b111 each rising edge of the selected trigger is one timer-clock tick. The edge is seen through a two-flop synchronizer, so a trigger held high gives exactly one tick. In every other slave mode each system clock cycle is a tick.
- R8: Trigger select values 0 to 3 pick trigIn[select]. Values 4 to 7 give a constant-low trigger. Slave mode and select are latched together on slaveWe, and pulses on unselected lines have no effect.
- R9: The overflow flag stays at 1 after an overflow event until ovfClr is pulsed. When a clear and an overflow event fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigIn | input | 4 | Internal trigger lines 0..3 |
| ctrlWe | input | 1 | Write strobe for enable and counting mode |
| ctrlEnable | input | 1 | Run enable value |
| ctrlCountMode | input | 2 | Counting mode value (2'b00 = up) |
| slaveWe | input | 1 | Write strobe for slave mode and trigger select |
| slaveMode | input | 3 | Slave mode value (3'b111 = trigger-clocked) |
| trigSel | input | 3 | Trigger select value |
| periodWe | input | 1 | Write strobe for the period |
| periodData | input | 16 | Period value |
| divWe | input | 1 | Write strobe for the divide shadow |
| divData | input | 16 | Divide value |
| ovfClr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Two functions can land in the same cycle. An overflow event can coincide with a software clear of the flag, and a divide write can coincide with a running prescaler period. The bench provokes the first by running with period 0, so every cycle overflows, and pulsing the clear during that run; it judges the result by the flag staying 1, and then by the flag reaching 0 once a clear follows a stop. It provokes the second by writing a new divide mid-period. It judges that case by the unchanged advance rate up to the wrap and the new rate right after it, with the counts predicted by a cycle model built from the requirements.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } count_mode_e;

  localparam logic [2:0] SLAVE_TRIG_CLK = 3'b111;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic run;        // enable set and up mode selected
    logic timerTick;  // one timer-clock tick this cycle
  } tmr_strobe_t;

endpackage

// File: rtl/trig_timer_ctl.sv
module trig_timer_ctl
  import trig_timer_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                ctrlWe,
  input  logic                ctrlEnable,
  input  logic [1:0]          ctrlCountMode,
  input  logic                slaveWe,
  input  logic [2:0]          slaveMode,
  input  logic [SEL_W-1:0]    trigSel,
  output tmr_strobe_t         strb
);

  logic             enableReg;
  count_mode_e      modeReg;
  logic [2:0]       slaveReg;
  logic [SEL_W-1:0] selReg;
  logic             selTrig;
  logic             sync1, sync2, syncPrev;
  logic             trigEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      modeReg   <= MODE_UP;
    end else if (ctrlWe) begin
      enableReg <= ctrlEnable;
      modeReg   <= count_mode_e'(ctrlCountMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveReg <= 3'b000;
      selReg   <= '0;
    end else if (slaveWe) begin
      slaveReg <= slaveMode;
      selReg   <= trigSel;
    end
  end

  // select mux: a select with no matching line yields constant low
  always_comb begin
    selTrig = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (int'(selReg) == i) selTrig = trigIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      sync1    <= selTrig;
      sync2    <= sync1;
      syncPrev <= sync2;
    end
  end

  assign trigEdge = sync2 & ~syncPrev;

  always_comb begin
    strb.run       = enableReg && (modeReg == MODE_UP);
    strb.timerTick = (slaveReg == SLAVE_TRIG_CLK) ? trigEdge : 1'b1;
  end

endmodule

// File: rtl/trig_timer_dp.sv
module trig_timer_dp
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  logic             periodWe,
  input  logic [CNT_W-1:0] periodData,
  input  logic             divWe,
  input  logic [DIV_W-1:0] divData,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             ovfEvt
);

  logic [CNT_W-1:0] periodReg;
  logic [DIV_W-1:0] divShadow;
  logic [DIV_W-1:0] divActive;
  logic [DIV_W-1:0] psCnt;
  logic             psStep;
  logic             psHit;

  assign psStep = strb.run && strb.timerTick;
  assign psHit  = psStep && (psCnt >= divActive);
  assign ovfEvt = psHit && (count >= periodReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      divShadow <= '0;
    end else begin
      if (periodWe) periodReg <= periodData;
      if (divWe)    divShadow <= divData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt     <= '0;
      divActive <= '0;
    end else begin
      if (psHit)       psCnt <= '0;
      else if (psStep) psCnt <= psCnt + DIV_W'(1);
      if (ovfEvt)      divActive <= divShadow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       count <= '0;
    else if (ovfEvt) count <= '0;
    else if (psHit)  count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovfFlag <= 1'b0;
    else if (ovfEvt) ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end

endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 16,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                ctrlWe,
  input  logic                ctrlEnable,
  input  logic [1:0]          ctrlCountMode,
  input  logic                slaveWe,
  input  logic [2:0]          slaveMode,
  input  logic [SEL_W-1:0]    trigSel,
  input  logic                periodWe,
  input  logic [CNT_W-1:0]    periodData,
  input  logic                divWe,
  input  logic [DIV_W-1:0]    divData,
  input  logic                ovfClr,
  output logic [CNT_W-1:0]    count,
  output logic                ovfFlag
);

  tmr_strobe_t strb;
  logic        ovfEvt;

  trig_timer_ctl #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .ctrlWe(ctrlWe), .ctrlEnable(ctrlEnable), .ctrlCountMode(ctrlCountMode),
    .slaveWe(slaveWe), .slaveMode(slaveMode), .trigSel(trigSel),
    .strb(strb)
  );

  trig_timer_dp #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .periodWe(periodWe), .periodData(periodData),
    .divWe(divWe), .divData(divData), .ovfClr(ovfClr),
    .count(count), .ovfFlag(ovfFlag), .ovfEvt(ovfEvt)
  );

endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input tmr_strobe_t      strb,
  input logic             ovfEvt,
  input logic             ovfClr,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag
);

  // R5 / R6: no run permission means the count holds
  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> $stable(count));

  // R3: without an overflow the count either holds or rises by one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    !ovfEvt |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  // R3: an overflow event leaves the count at zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> (count == '0));

  // R9: overflow sets the flag, even against a clear in the same cycle
  a_r9_overflow_wins: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> ovfFlag);

  // R9: a clear with no overflow drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !ovfEvt) |=> !ovfFlag);

  // R9: the flag never rises without an overflow event
  a_r9_sticky_source: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfFlag && !ovfEvt) |=> !ovfFlag);

endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .ovfEvt(ovfEvt),
  .ovfClr(ovfClr), .count(count), .ovfFlag(ovfFlag)
);

// File: tb/trig_timer_test.sv
`timescale 1ns/1ps
module trig_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  trigIn = '0;
  logic        ctrlWe = 1'b0, ctrlEnable = 1'b0;
  logic [1:0]  ctrlCountMode = 2'b00;
  logic        slaveWe = 1'b0;
  logic [2:0]  slaveMode = 3'b000, trigSel = 3'b000;
  logic        periodWe = 1'b0, divWe = 1'b0, ovfClr = 1'b0;
  logic [15:0] periodData = '0, divData = '0;
  logic [15:0] count;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_timer uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .ctrlWe(ctrlWe), .ctrlEnable(ctrlEnable), .ctrlCountMode(ctrlCountMode),
    .slaveWe(slaveWe), .slaveMode(slaveMode), .trigSel(trigSel),
    .periodWe(periodWe), .periodData(periodData),
    .divWe(divWe), .divData(divData), .ovfClr(ovfClr),
    .count(count), .ovfFlag(ovfFlag)
  );

  // vector: period, divide, enabled cycles
  localparam int NV = 5;
  localparam logic [15:0] VEC [NV][3] = '{
    '{16'd5,    16'd0, 16'd20},
    '{16'd3,    16'd2, 16'd40},
    '{16'h0032, 16'd0, 16'd60},
    '{16'd2,    16'd3, 16'd50},
    '{16'd0,    16'd1, 16'd10}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic wrCtrl(bit en, logic [1:0] mode);
    ctrlWe = 1'b1; ctrlEnable = en; ctrlCountMode = mode;
    cyc(1);
    ctrlWe = 1'b0;
  endtask

  task automatic wrSlave(logic [2:0] mode, logic [2:0] sel);
    slaveWe = 1'b1; slaveMode = mode; trigSel = sel;
    cyc(1);
    slaveWe = 1'b0;
  endtask

  task automatic wrPeriod(logic [15:0] p);
    periodWe = 1'b1; periodData = p;
    cyc(1);
    periodWe = 1'b0;
  endtask

  task automatic wrDiv(logic [15:0] d);
    divWe = 1'b1; divData = d;
    cyc(1);
    divWe = 1'b0;
  endtask

  task automatic pulses(logic [3:0] mask, int n);
    for (int k = 0; k < n; k++) begin
      trigIn = mask; cyc(3);
      trigIn = '0;   cyc(3);
    end
    cyc(4);
  endtask

  // model built from R2, R3, R4, R9: active divide starts at 0
  task automatic model(int p, int d, int n, output int cnt, output int flg);
    int act = 0, ps = 0;
    cnt = 0; flg = 0;
    for (int i = 0; i < n; i++) begin
      if (ps >= act) begin
        ps = 0;
        if (cnt >= p) begin cnt = 0; flg = 1; act = d; end
        else cnt++;
      end else ps++;
    end
  endtask

  initial begin
    int expCnt, expFlg;
    doReset();
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 flag", ovfFlag, 0);

    // R2 R3 R4: table of internal-clock runs
    for (int v = 0; v < NV; v++) begin
      doReset();
      wrPeriod(VEC[v][0]);
      wrDiv(VEC[v][1]);
      wrCtrl(1'b1, 2'b00);
      cyc(int'(VEC[v][2]));
      model(int'(VEC[v][0]), int'(VEC[v][1]), int'(VEC[v][2]), expCnt, expFlg);
      check("R2/R3 count", count, expCnt);
      check("R3 flag", ovfFlag, expFlg);
    end

    // R4: divide write buffered until overflow
    doReset();
    wrPeriod(16'd10);
    wrCtrl(1'b1, 2'b00);
    cyc(3);
    wrDiv(16'd2);
    cyc(2);
    check("R4 old divide kept", count, 6);
    cyc(5);
    check("R4 wrap", count, 0);
    cyc(3);
    check("R4 new divide after overflow", count, 1);
    cyc(3);
    check("R4 new divide rate", count, 2);

    // R5 enable and R6 mode
    doReset();
    wrPeriod(16'd100);
    wrCtrl(1'b1, 2'b00);
    cyc(5);
    wrCtrl(1'b0, 2'b00);
    cyc(10);
    check("R5 hold when disabled", count, 6);
    wrCtrl(1'b1, 2'b01);
    cyc(10);
    check("R6 hold in non-up mode", count, 6);
    wrCtrl(1'b1, 2'b00);
    cyc(4);
    check("R6 up mode resumes", count, 10);

    // R7 R8: trigger-clocked mode
    doReset();
    wrPeriod(16'd1000);
    wrSlave(3'b111, 3'd1);
    wrCtrl(1'b1, 2'b00);
    check("R7 no ticks without edges", count, 0);
    pulses(4'b0010, 5);
    check("R7 one count per edge", count, 5);
    pulses(4'b1101, 4);
    check("R8 unselected lines ignored", count, 5);
    wrSlave(3'b111, 3'd4);
    pulses(4'b1111, 3);
    check("R8 absent select is low", count, 5);
    wrSlave(3'b111, 3'd2);
    trigIn = 4'b0100;
    cyc(20);
    check("R7 held high gives one tick", count, 6);
    trigIn = '0;
    cyc(4);

    // R9: clear against overflow in the same cycle
    doReset();
    wrPeriod(16'd0);
    wrCtrl(1'b1, 2'b00);
    cyc(2);
    check("R9 flag set", ovfFlag, 1);
    ovfClr = 1'b1; cyc(1); ovfClr = 1'b0;
    check("R9 overflow wins over clear", ovfFlag, 1);
    wrCtrl(1'b0, 2'b00);
    cyc(2);
    check("R9 flag sticky", ovfFlag, 1);
    ovfClr = 1'b1; cyc(1); ovfClr = 1'b0;
    check("R9 clear", ovfFlag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule